// File: doc/BRIEF.md
# Pixel Cluster Seed Locator

This block turns one captured patch of a pixel sensor into cluster positions. The patch holds ROWS x COLS pixels (6 rows by 12 columns by default). It also carries the patch's base row and column on the detector and a 2-bit sensor number. A pulse on `eoe_i` marks the end of the event. On that pulse the block latches the patch and checks every pixel at once against a fixed seeding pattern. The pattern is mirrored left to right for sensors whose mounting orientation is reversed.

Each seed pixel opens a 3x3 window: its own row and the two rows above it, and its own column with one column on each side. A lookup table turns the 9-bit window into a centroid offset with FRAC fractional bits. The absolute position is the sum of three terms: the patch base, the seed's place inside the patch, and that offset. The block sends the clusters out one per clock in a fixed scan order. It then pulses `done_o`.

Top module: `cluster_seed_locator`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no event given, `clu_valid_o` and `done_o` are 0.
- R2: When `eoe_i` is sampled high while the block is idle, the block captures `pix_i`, `sensor_i`, `base_row_i` and `base_col_i` at that edge. The first cluster appears on the outputs after the next rising edge. Pixel (r, c) is bit r*COLS+c of `pix_i`, and row 0 is the lowest row.
- R3: For sensor numbers 0 and 3, pixel (r, c) is a seed when four conditions hold: it is active, (r, c-1) is inactive, and (r-1, c-1), (r-1, c) and (r-1, c+1) are all inactive. All other neighbours are ignored.
- R4: For sensor numbers 1 and 2, the rule is mirrored. The right neighbour (r, c+1) must be inactive in place of the left one, and the same three pixels of row r-1 must be inactive.
- R5: A position outside the patch counts as an inactive pixel, both in the seed test and in the window.
- R6: A seed's window covers rows r..r+2 and columns c-1..c+1. Window bit index is 3*dy+dx, with dy = row-r and dx = col-c+1. Active pixels outside the window have no effect on that cluster.
- R7: With n active window pixels, sx = sum of dx and sy = sum of dy, the offsets are ox = (4*sx + n/2)/n and oy = (4*sy + n/2)/n, using integer division. The unit is a quarter pixel (FRAC=2).
- R8: The reported position is `clu_row_o` = 4*(base_row+r) + oy and `clu_col_o` = 4*(base_col+c) + ox - 4.
- R9: Clusters come out one per clock with `clu_valid_o` high. They are ordered by ascending index r*COLS+c, so row 0 comes first and lower columns come first within a row. There is exactly one output per seed.
- R10: `done_o` is high for exactly one cycle, in the cycle right after the last cluster. When an event has no seeds, `done_o` is high in the cycle after the capture edge's next edge.
- R11: An `eoe_i` pulse that arrives before `done_o` has been given for the current event is ignored. The output sequence stays that of the captured event, and no further output follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eoe_i | input | 1 | End of event: capture the patch and start |
| sensor_i | input | 2 | Sensor number; 1 and 2 select the mirrored pattern |
| base_row_i | input | CW (10) | Patch base row on the detector, in pixels |
| base_col_i | input | CW (10) | Patch base column on the detector, in pixels |
| pix_i | input | ROWS*COLS (72) | Pixel hits, bit r*COLS+c |
| clu_valid_o | output | 1 | A cluster position is present |
| clu_row_o | output | CW+FRAC (12) | Absolute cluster row, in quarter pixels |
| clu_col_o | output | CW+FRAC (12) | Absolute cluster column, in quarter pixels |
| done_o | output | 1 | One-cycle pulse after the last cluster of the event |

## Verification
A fault in the seed mask shows up at once, in the first output cycle after capture, as a missing, extra or reordered cluster. It also moves the `done_o` pulse by the same number of cycles. A wrong window or table entry shows up only in the coordinate of the affected cluster, and only in the cycle that cluster is sent. For this reason the directed events put seeds at patch edges and give them windows with one, two, three and more pixels, in both orientations. A busy flag that clears early shows up as a second event's clusters or an extra `done_o` after the expected pulse.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int unsigned WIN_W = 9;
  localparam int unsigned WIN_N = 1 << WIN_W;

  // sensors 1 and 2 are mounted mirrored
  function automatic logic sensor_mirrored(input logic [1:0] sensor);
    return sensor[0] ^ sensor[1];
  endfunction
endpackage

// File: rtl/csl_seed_match.sv
module csl_seed_match #(
  parameter int unsigned ROWS = 6,
  parameter int unsigned COLS = 12,
  localparam int unsigned N = ROWS * COLS
) (
  input  logic [N-1:0] pix_i,
  input  logic         mirror_i,
  output logic [N-1:0] seed_o
);
  // one ring of inactive pixels around the patch
  logic [COLS+1:0] pad [ROWS+2];

  always_comb begin
    for (int r = 0; r < ROWS + 2; r++) pad[r] = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        pad[r+1][c+1] = pix_i[r*COLS+c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic side_q;
      logic below_clear;
      assign side_q      = mirror_i ? pad[r+1][c+2] : pad[r+1][c];
      assign below_clear = ~(pad[r][c] | pad[r][c+1] | pad[r][c+2]);
      assign seed_o[r*COLS+c] = pad[r+1][c+1] & ~side_q & below_clear;
    end
  end
endmodule

// File: rtl/csl_prio_enc.sv
module csl_prio_enc #(
  parameter int unsigned N = 72,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csl_window_lut.sv
module csl_window_lut
  import csl_pkg::*;
#(
  parameter int unsigned ROWS = 6,
  parameter int unsigned COLS = 12,
  parameter int unsigned FRAC = 2,
  localparam int unsigned N   = ROWS * COLS,
  localparam int unsigned RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned OFW = FRAC + 2
) (
  input  logic [N-1:0]   pix_i,
  input  logic [RW-1:0]  row_i,
  input  logic [CLW-1:0] col_i,
  output logic [OFW-1:0] ox_o,
  output logic [OFW-1:0] oy_o
);
  localparam int unsigned SCALE = 1 << FRAC;

  function automatic logic [OFW-1:0] centroid(input logic [WIN_W-1:0] w, input logic xaxis);
    int n, s;
    n = 0;
    s = 0;
    for (int k = 0; k < WIN_W; k++) begin
      if (w[k]) begin
        n++;
        s += xaxis ? (k % 3) : (k / 3);
      end
    end
    if (n == 0) return xaxis ? OFW'(SCALE) : '0;
    return OFW'(((s * SCALE) + n / 2) / n);
  endfunction

  logic [OFW-1:0] lut_x [WIN_N];
  logic [OFW-1:0] lut_y [WIN_N];

  for (genvar a = 0; a < WIN_N; a++) begin : g_lut
    assign lut_x[a] = centroid(WIN_W'(a), 1'b1);
    assign lut_y[a] = centroid(WIN_W'(a), 1'b0);
  end

  logic [WIN_W-1:0] win;

  always_comb begin
    win = '0;
    for (int dy = 0; dy < 3; dy++) begin
      for (int dx = 0; dx < 3; dx++) begin
        int rr, cc;
        rr = int'(row_i) + dy;
        cc = int'(col_i) + dx - 1;
        if (rr < int'(ROWS) && cc >= 0 && cc < int'(COLS))
          win[dy*3+dx] = pix_i[rr*int'(COLS)+cc];
      end
    end
  end

  assign ox_o = lut_x[win];
  assign oy_o = lut_y[win];
endmodule

// File: rtl/cluster_seed_locator.sv
module cluster_seed_locator
  import csl_pkg::*;
#(
  parameter int unsigned ROWS = 6,
  parameter int unsigned COLS = 12,
  parameter int unsigned CW   = 10,
  parameter int unsigned FRAC = 2,
  localparam int unsigned N   = ROWS * COLS,
  localparam int unsigned OW  = CW + FRAC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eoe_i,
  input  logic [1:0]    sensor_i,
  input  logic [CW-1:0] base_row_i,
  input  logic [CW-1:0] base_col_i,
  input  logic [N-1:0]  pix_i,
  output logic          clu_valid_o,
  output logic [OW-1:0] clu_row_o,
  output logic [OW-1:0] clu_col_o,
  output logic          done_o
);
  localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned CLW   = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int unsigned OFW   = FRAC + 2;
  localparam int unsigned SCALE = 1 << FRAC;

  logic          busy_q;
  logic [N-1:0]  pix_q;
  logic [N-1:0]  seed_q;
  logic [CW-1:0] base_row_q;
  logic [CW-1:0] base_col_q;
  logic [IW-1:0] idx_q;

  logic [N-1:0]   seed_now;
  logic [IW-1:0]  sel_idx;
  logic           sel_any;
  logic [RW-1:0]  sel_row;
  logic [CLW-1:0] sel_col;
  logic [OFW-1:0] off_x;
  logic [OFW-1:0] off_y;
  logic [OW-1:0]  pos_row;
  logic [OW-1:0]  pos_col;

  csl_seed_match #(.ROWS(ROWS), .COLS(COLS)) u_seed (
    .pix_i    (pix_i),
    .mirror_i (sensor_mirrored(sensor_i)),
    .seed_o   (seed_now)
  );

  csl_prio_enc #(.N(N)) u_pick (
    .req_i (seed_q),
    .idx_o (sel_idx),
    .any_o (sel_any)
  );

  always_comb begin
    sel_row = RW'(int'(sel_idx) / int'(COLS));
    sel_col = CLW'(int'(sel_idx) % int'(COLS));
  end

  csl_window_lut #(.ROWS(ROWS), .COLS(COLS), .FRAC(FRAC)) u_lut (
    .pix_i (pix_q),
    .row_i (sel_row),
    .col_i (sel_col),
    .ox_o  (off_x),
    .oy_o  (off_y)
  );

  // patch base + seed place + window centroid
  always_comb begin
    pos_row = ((OW'(base_row_q) + OW'(sel_row)) << FRAC) + OW'(off_y);
    pos_col = ((OW'(base_col_q) + OW'(sel_col)) << FRAC) + OW'(off_x) - OW'(SCALE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      pix_q       <= '0;
      seed_q      <= '0;
      base_row_q  <= '0;
      base_col_q  <= '0;
      idx_q       <= '0;
      clu_valid_o <= 1'b0;
      clu_row_o   <= '0;
      clu_col_o   <= '0;
      done_o      <= 1'b0;
    end else begin
      clu_valid_o <= 1'b0;
      done_o      <= 1'b0;
      if (!busy_q) begin
        if (eoe_i) begin
          busy_q     <= 1'b1;
          pix_q      <= pix_i;
          seed_q     <= seed_now;
          base_row_q <= base_row_i;
          base_col_q <= base_col_i;
        end
      end else if (sel_any) begin
        clu_valid_o     <= 1'b1;
        clu_row_o       <= pos_row;
        clu_col_o       <= pos_col;
        seed_q[sel_idx] <= 1'b0;
        idx_q           <= sel_idx;
      end else begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  AST_VALID_IN_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o |-> busy_q); // R9
  AST_ONE_SEED_PER_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o |-> ($countones(seed_q) + 1 == $past($countones(seed_q)))); // R9
  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o |-> ((seed_q & ({N{1'b1}} >> (N - 1 - int'(idx_q)))) == '0)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!clu_valid_o && !busy_q)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_SEED_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((seed_q & ~pix_q) == '0)); // R3
  AST_PATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(pix_q)); // R11
endmodule

// File: tb/sim_cluster_seed_locator.sv
`timescale 1ns/1ps
module sim_cluster_seed_locator;
  localparam int ROWS = 6;
  localparam int COLS = 12;
  localparam int N    = ROWS * COLS;
  localparam int CW   = 10;
  localparam int OW   = CW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eoe = 1'b0;
  logic [1:0]    sensor = '0;
  logic [CW-1:0] base_row = '0;
  logic [CW-1:0] base_col = '0;
  logic [N-1:0]  pix = '0;
  logic          clu_valid;
  logic [OW-1:0] clu_row;
  logic [OW-1:0] clu_col;
  logic          done;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  int exp_n;
  int exp_row [N];
  int exp_col [N];
  int got_n;
  int got_row [N];
  int got_col [N];

  always #2.5 clk = ~clk;

  cluster_seed_locator u0 (
    .clk_i(clk), .rst_ni(rst_n), .eoe_i(eoe), .sensor_i(sensor),
    .base_row_i(base_row), .base_col_i(base_col), .pix_i(pix),
    .clu_valid_o(clu_valid), .clu_row_o(clu_row), .clu_col_o(clu_col), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit px(input logic [N-1:0] p, input int r, input int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0; // R5
    return p[r*COLS+c];
  endfunction

  function automatic bit is_seed(input logic [N-1:0] p, input int r, input int c, input bit mir);
    int side;
    side = mir ? c + 1 : c - 1; // R3 / R4
    return px(p, r, c) && !px(p, r, side) && !px(p, r-1, c-1) && !px(p, r-1, c) && !px(p, r-1, c+1);
  endfunction

  task automatic build_expect(input logic [N-1:0] p, input logic [1:0] s, input int br, input int bc);
    bit mir;
    mir = (s == 2'd1) || (s == 2'd2);
    exp_n = 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (is_seed(p, r, c, mir)) begin
          int n, sx, sy, ox, oy;
          n = 0; sx = 0; sy = 0;
          for (int dy = 0; dy < 3; dy++)
            for (int dx = 0; dx < 3; dx++)
              if (px(p, r+dy, c+dx-1)) begin n++; sx += dx; sy += dy; end // R6
          ox = (4*sx + n/2) / n; // R7
          oy = (4*sy + n/2) / n;
          exp_row[exp_n] = 4*(br + r) + oy; // R8
          exp_col[exp_n] = 4*(bc + c) + ox - 4;
          exp_n++;
        end
      end
    end
  endtask

  // run one event; inject drives a second eoe while busy
  task automatic run_event(input logic [N-1:0] p, input logic [1:0] s, input int br, input int bc,
                           input bit inject, input string tag);
    build_expect(p, s, br, bc);
    got_n = 0;
    @(negedge clk);
    pix = p; sensor = s; base_row = CW'(br); base_col = CW'(bc); eoe = 1'b1;
    @(negedge clk);
    eoe = 1'b0;
    for (int k = 1; k <= exp_n + 1; k++) begin
      if (inject && k == 1) begin
        pix = ~p; sensor = s ^ 2'd1; base_row = CW'(br + 7); eoe = 1'b1;
      end
      @(negedge clk);
      eoe = 1'b0;
      if (k <= exp_n) begin
        check(clu_valid === 1'b1, "R9", {tag, " valid"}, int'(clu_valid), 1);
        check(int'(clu_row) == exp_row[k-1], "R8", {tag, " row"}, int'(clu_row), exp_row[k-1]);
        check(int'(clu_col) == exp_col[k-1], "R8", {tag, " col"}, int'(clu_col), exp_col[k-1]);
        check(done === 1'b0, "R10", {tag, " early done"}, int'(done), 0);
        got_row[got_n] = int'(clu_row);
        got_col[got_n] = int'(clu_col);
        got_n++;
      end else begin
        check(clu_valid === 1'b0, "R9", {tag, " extra cluster"}, int'(clu_valid), 0);
        check(done === 1'b1, "R10", {tag, " done"}, int'(done), 1);
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(clu_valid === 1'b0 && done === 1'b0, "R11", {tag, " quiet after done"},
            int'(clu_valid) + 2*int'(done), 0);
    end
  endtask

  function automatic logic [N-1:0] bitat(input int r, input int c);
    return N'(1) << (r*COLS + c);
  endfunction

  task automatic t_reset;
    check(clu_valid === 1'b0, "R1", "valid after reset", int'(clu_valid), 0);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_single;
    run_event(bitat(2, 3), 2'd0, 10, 20, 1'b0, "single");
    check(got_n == 1, "R2", "single count", got_n, 1);
    check(got_row[0] == 48, "R8", "single row", got_row[0], 48);
    check(got_col[0] == 92, "R8", "single col", got_col[0], 92);
  endtask

  task automatic t_pair_orient;
    run_event(bitat(1, 4) | bitat(1, 5), 2'd0, 0, 0, 1'b0, "pair_s0");
    check(got_n == 1 && got_col[0] == 18, "R3", "pair sensor0 col", got_col[0], 18);
    check(got_row[0] == 4, "R7", "pair sensor0 row", got_row[0], 4);
    run_event(bitat(1, 4) | bitat(1, 5), 2'd1, 0, 0, 1'b0, "pair_s1");
    check(got_n == 1 && got_col[0] == 18, "R4", "pair sensor1 col", got_col[0], 18);
    run_event(bitat(2, 3) | bitat(1, 4), 2'd3, 0, 0, 1'b0, "diag_s3");
    check(got_n == 1, "R3", "diag sensor3 count", got_n, 1);
    run_event(bitat(2, 5) | bitat(1, 4), 2'd2, 0, 0, 1'b0, "diag_s2");
    check(got_n == 1, "R4", "diag sensor2 count", got_n, 1);
  endtask

  task automatic t_edges;
    run_event(bitat(0, 0) | bitat(5, 11) | bitat(5, 0), 2'd3, 3, 5, 1'b0, "edges");
    check(got_n == 3, "R5", "edge seeds", got_n, 3);
    check(got_col[0] == 20, "R5", "corner col", got_col[0], 20);
    check(got_row[2] == 32 && got_col[2] == 64, "R9", "last in order", got_col[2], 64);
  endtask

  task automatic t_big;
    logic [N-1:0] p;
    p = '0;
    for (int r = 0; r < ROWS; r++) p |= bitat(r, 5);
    run_event(p, 2'd0, 0, 0, 1'b0, "column");
    check(got_n == 1, "R6", "tall cluster count", got_n, 1);
    check(got_row[0] == 4, "R6", "tall cluster row", got_row[0], 4);
    check(got_col[0] == 20, "R6", "tall cluster col", got_col[0], 20);
  endtask

  task automatic t_many;
    run_event(72'h91_0C30_8421_0842_A5C3, 2'd2, 100, 200, 1'b0, "mix_s2");
    run_event(72'h91_0C30_8421_0842_A5C3, 2'd0, 1000, 1000, 1'b0, "mix_s0");
    run_event(72'hF0_F0F0_0F0F_3C3C_C3C3, 2'd1, 7, 9, 1'b0, "dense_s1");
    check(exp_n > 1, "R9", "dense has several seeds", exp_n, 2);
  endtask

  task automatic t_empty;
    run_event('0, 2'd0, 1, 1, 1'b0, "empty");
    check(got_n == 0, "R10", "empty count", got_n, 0);
  endtask

  task automatic t_ignore;
    run_event(bitat(3, 6) | bitat(3, 7) | bitat(0, 2), 2'd0, 4, 4, 1'b1, "ignore");
    check(got_n == 2, "R11", "ignore count", got_n, 2);
    run_event('0, 2'd0, 0, 0, 1'b1, "ignore_empty");
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_pair_orient();
    t_edges();
    t_big();
    t_many();
    t_empty();
    t_ignore();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule